// File: doc/BRIEF.md
# Saturating Noise Injection Channel

This block models the digital channel between a baseband transmitter and its receiver. Each transmit bit becomes a signed 8-bit sample, much like a converter reading. A 1 maps to plus half of the positive range and a 0 maps to the negative of that value. Injection can be switched on and off at any time, for example only during a packet payload and not during the preamble. While it is on, a signed 9-bit noise sample from an external sample source is added to the mapped value. The sum is clipped to the 8-bit range, registered, and passed to the receiver together with a flag that marks clipping.

Two accumulators gather running statistics of every valid sample. One takes the unclipped sum, the other takes the clipped output. Each holds a running sum (for the mean) and a running sum of squares (for the power), and a shared counter holds the number of samples. A two-entry register port sets the injection enable and clears the statistics.

Top module: `sat_noise_channel`

## Requirements
- R1: After reset, rx_valid, rx_sample and rx_clip are 0, injection is disabled, and all statistics and the sample count are 0.
- R2: A valid transmit bit appears at rx_sample on the clock cycle after tx_valid, with rx_valid high in that cycle. With injection off, bit 1 gives +64 and bit 0 gives -64 in two's complement.
- R3: With injection on, rx_sample equals the mapped value plus noise_sample read as signed two's complement, when that sum lies within -128..+127.
- R4: A sum above +127 gives +127 and a sum below -128 gives -128. rx_clip is 1 in the same cycle as such a sample and is 0 otherwise.
- R5: With injection off, noise_sample has no effect on rx_sample or on any statistic.
- R6: noise_req equals tx_valid AND the injection enable, in the same cycle and without a register.
- R7: pre_sum and pre_sq accumulate the unclipped sum and its square, as 48-bit two's-complement and unsigned values, one term per valid sample.
- R8: post_sum and post_sq accumulate the clipped output value and its square, one term per valid sample.
- R9: stat_count increases by one for each valid sample.
- R10: A write with cfg_sel=1 zeroes all statistics and the count on that edge. A valid sample in the same cycle is not accumulated, but it is still delivered at rx_sample.
- R11: A write with cfg_sel=0 loads cfg_wdata as the injection enable. The new value applies from the next cycle.
- R12: With tx_valid low, rx_valid is 0 on the next cycle, rx_sample holds its value, and the statistics do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Transmit bit is present |
| tx_bit | input | 1 | Transmit bit |
| noise_req | output | 1 | Noise sample is consumed in this cycle |
| noise_sample | input | 9 | Signed noise sample, valid in the cycle of noise_req |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0: injection enable, 1: clear statistics |
| cfg_wdata | input | 1 | Enable value written when cfg_sel=0 |
| rx_valid | output | 1 | rx_sample holds a new sample |
| rx_sample | output | 8 | Signed, clipped sample sent to the receiver |
| rx_clip | output | 1 | The current sample was clipped |
| stat_count | output | 48 | Number of accumulated samples |
| pre_sum | output | 48 | Sum of the unclipped samples |
| pre_sq | output | 48 | Sum of squares of the unclipped samples |
| post_sum | output | 48 | Sum of the output samples |
| post_sq | output | 48 | Sum of squares of the output samples |

## Verification
The bench drives sums one step either side of each clip limit (+127/+128 and -128/-129) and the extreme noise codes +255 and -256. A design with an off-by-one limit or a carry lost in the sign extension would wrap instead of clipping, or would flag samples that fit. It drives large noise while injection is off, which a design that does not gate the noise operand would let through to the output and into the statistics. It issues a clear in the same cycle as a valid sample, which a design that gives accumulation priority would leave with a count of 1. It toggles the enable between samples, so the effect of a write taking hold one cycle early or late shows up in the outputs. Random sample streams compare the pre-clip and post-clip sums, the sums of squares and the count against an independent model, which catches a design that feeds one accumulator from the wrong side of the clipper.

// File: rtl/snc_pkg.sv
package snc_pkg;
    typedef enum logic {
        SEL_INJ_EN = 1'b0,
        SEL_CLEAR  = 1'b1
    } cfg_sel_e;
endpackage

// File: rtl/snc_mapper.sv
module snc_mapper #(
    parameter int SAMP_W = 8
) (
    input  logic                     bit_in,
    output logic signed [SAMP_W-1:0] level
);
    localparam int AMP = 2 ** (SAMP_W - 2);

    always_comb begin
        level = bit_in ? SAMP_W'(AMP) : SAMP_W'(-AMP);
    end
endmodule

// File: rtl/snc_sat_adder.sv
module snc_sat_adder #(
    parameter int SAMP_W  = 8,
    parameter int NOISE_W = 9,
    parameter int SUM_W   = 10
) (
    input  logic signed [SAMP_W-1:0]  base,
    input  logic signed [NOISE_W-1:0] noise,
    input  logic                      noise_on,
    output logic signed [SUM_W-1:0]   raw,
    output logic signed [SAMP_W-1:0]  clipped,
    output logic                      clip
);
    localparam int TOP_W = SUM_W - SAMP_W + 1;

    logic signed [SUM_W-1:0] noise_ext;
    logic        [TOP_W-1:0] top_bits;

    always_comb begin
        noise_ext = noise_on ? SUM_W'(noise) : '0;
        raw       = SUM_W'(base) + noise_ext;
        top_bits  = raw[SUM_W-1:SAMP_W-1];
        clip      = !((&top_bits) || !(|top_bits));
        if (!clip) begin
            clipped = raw[SAMP_W-1:0];
        end else if (raw[SUM_W-1]) begin
            clipped = {1'b1, {(SAMP_W-1){1'b0}}};
        end else begin
            clipped = {1'b0, {(SAMP_W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/snc_stat_acc.sv
module snc_stat_acc #(
    parameter int IN_W  = 10,
    parameter int ACC_W = 48
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   add,
    input  logic signed [IN_W-1:0] x,
    output logic [ACC_W-1:0]       sum,
    output logic [ACC_W-1:0]       sq
);
    localparam int PROD_W = 2 * IN_W;

    typedef struct packed {
        logic [ACC_W-1:0] sum;
        logic [ACC_W-1:0] sq;
    } acc_t;

    acc_t                     st_d, st_q;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(x) * PROD_W'(x);
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (add) begin
            st_d.sum = st_q.sum + ACC_W'(x);
            st_d.sq  = st_q.sq + {{(ACC_W-PROD_W){1'b0}}, prod};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sum = st_q.sum;
    assign sq  = st_q.sq;

    // R10
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum == '0 && sq == '0));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !add) |=> ($stable(sum) && $stable(sq)));
endmodule

// File: rtl/sat_noise_channel.sv
module sat_noise_channel #(
    parameter int SAMP_W  = 8,
    parameter int NOISE_W = 9,
    parameter int ACC_W   = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_valid,
    input  logic               tx_bit,
    output logic               noise_req,
    input  logic [NOISE_W-1:0] noise_sample,
    input  logic               cfg_wr,
    input  logic               cfg_sel,
    input  logic               cfg_wdata,
    output logic               rx_valid,
    output logic [SAMP_W-1:0]  rx_sample,
    output logic               rx_clip,
    output logic [ACC_W-1:0]   stat_count,
    output logic [ACC_W-1:0]   pre_sum,
    output logic [ACC_W-1:0]   pre_sq,
    output logic [ACC_W-1:0]   post_sum,
    output logic [ACC_W-1:0]   post_sq
);
    import snc_pkg::*;

    localparam int SUM_W  = ((NOISE_W > SAMP_W) ? NOISE_W : SAMP_W) + 1;
    localparam int N_ACC  = 2;
    localparam int AMP    = 2 ** (SAMP_W - 2);

    typedef struct packed {
        logic              inj_en;
        logic              rx_valid;
        logic [SAMP_W-1:0] rx_sample;
        logic              rx_clip;
        logic [ACC_W-1:0]  count;
    } state_t;

    state_t st_d, st_q;

    logic signed [SAMP_W-1:0] mapped;
    logic signed [SUM_W-1:0]  raw_sum;
    logic signed [SAMP_W-1:0] sat_val;
    logic                     sat_hit;
    logic                     clr_hit;
    logic                     en_wr;
    logic signed [SUM_W-1:0]  acc_in [N_ACC];
    logic [ACC_W-1:0]         acc_sum [N_ACC];
    logic [ACC_W-1:0]         acc_sq  [N_ACC];

    snc_mapper #(.SAMP_W(SAMP_W)) u_map (
        .bit_in (tx_bit),
        .level  (mapped)
    );

    snc_sat_adder #(.SAMP_W(SAMP_W), .NOISE_W(NOISE_W), .SUM_W(SUM_W)) u_add (
        .base     (mapped),
        .noise    (noise_sample),
        .noise_on (st_q.inj_en),
        .raw      (raw_sum),
        .clipped  (sat_val),
        .clip     (sat_hit)
    );

    always_comb begin
        clr_hit   = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_CLEAR);
        en_wr     = cfg_wr && (cfg_sel_e'(cfg_sel) == SEL_INJ_EN);
        acc_in[0] = raw_sum;
        acc_in[1] = SUM_W'(sat_val);
    end

    for (genvar g = 0; g < N_ACC; g++) begin : g_acc
        snc_stat_acc #(.IN_W(SUM_W), .ACC_W(ACC_W)) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_hit),
            .add   (tx_valid),
            .x     (acc_in[g]),
            .sum   (acc_sum[g]),
            .sq    (acc_sq[g])
        );
    end

    always_comb begin
        st_d          = st_q;
        st_d.rx_valid = tx_valid;
        if (en_wr) begin
            st_d.inj_en = cfg_wdata;
        end
        if (tx_valid) begin
            st_d.rx_sample = sat_val;
            st_d.rx_clip   = sat_hit;
        end else begin
            st_d.rx_clip   = 1'b0;
        end
        if (clr_hit) begin
            st_d.count = '0;
        end else if (tx_valid) begin
            st_d.count = st_q.count + ACC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign noise_req  = tx_valid && st_q.inj_en;
    assign rx_valid   = st_q.rx_valid;
    assign rx_sample  = st_q.rx_sample;
    assign rx_clip    = st_q.rx_clip;
    assign stat_count = st_q.count;
    assign pre_sum    = acc_sum[0];
    assign pre_sq     = acc_sq[0];
    assign post_sum   = acc_sum[1];
    assign post_sq    = acc_sq[1];

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid == $past(tx_valid));

    // R4
    clip_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clip |-> (rx_sample == {1'b0, {(SAMP_W-1){1'b1}}} ||
                     rx_sample == {1'b1, {(SAMP_W-1){1'b0}}}));

    // R5
    quiet_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(st_q.inj_en)) |->
        (rx_sample == SAMP_W'(AMP) || rx_sample == SAMP_W'(-AMP)));

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(clr_hit)) |-> stat_count == $past(stat_count) + ACC_W'(1));

    // R10
    count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> stat_count == '0);
endmodule

// File: tb/sat_noise_channel_bench.sv
module sat_noise_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_valid = 1'b0;
    logic        tx_bit = 1'b0;
    logic        noise_req;
    logic [8:0]  noise_sample = '0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic        cfg_wdata = 1'b0;
    logic        rx_valid;
    logic [7:0]  rx_sample;
    logic        rx_clip;
    logic [47:0] stat_count, pre_sum, pre_sq, post_sum, post_sq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    bit          m_inj = 0;
    int          m_out = 0;
    bit          m_clip = 0;
    bit          m_valid = 0;
    logic [47:0] m_cnt = '0, m_psum = '0, m_psq = '0, m_osum = '0, m_osq = '0;

    sat_noise_channel u_sat_noise_channel (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_bit(tx_bit),
        .noise_req(noise_req), .noise_sample(noise_sample),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rx_valid(rx_valid), .rx_sample(rx_sample), .rx_clip(rx_clip),
        .stat_count(stat_count), .pre_sum(pre_sum), .pre_sq(pre_sq),
        .post_sum(post_sum), .post_sq(post_sq)
    );

    always #10 clk = ~clk;

    function automatic int map_bit(bit b);
        return b ? 64 : -64;
    endfunction

    function automatic int clip_val(int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        chk(rx_valid == m_valid, "R2/R12 rx_valid", rx_valid, m_valid);
        chk(int'($signed(rx_sample)) == m_out, "R2/R3/R4/R5 rx_sample", $signed(rx_sample), m_out);
        chk(rx_clip == m_clip, "R4 rx_clip", rx_clip, m_clip);
        chk(stat_count == m_cnt, "R9/R10 stat_count", stat_count, m_cnt);
        chk(pre_sum == m_psum, "R7 pre_sum", pre_sum, m_psum);
        chk(pre_sq == m_psq, "R7 pre_sq", pre_sq, m_psq);
        chk(post_sum == m_osum, "R8 post_sum", post_sum, m_osum);
        chk(post_sq == m_osq, "R8 post_sq", post_sq, m_osq);
    endtask

    // one cycle: inputs at negedge, model at posedge, check at next negedge
    task automatic step(bit v, bit b, int noise, bit wr, bit sel, bit wd);
        int raw;
        int o;
        tx_valid = v; tx_bit = b; noise_sample = 9'(noise);
        cfg_wr = wr; cfg_sel = sel; cfg_wdata = wd;
        #1;
        chk(noise_req == (v && m_inj), "R6 noise_req", noise_req, v && m_inj);
        @(posedge clk);
        m_valid = v;
        m_clip = 0;
        if (v) begin
            raw = map_bit(b) + (m_inj ? noise : 0);
            o = clip_val(raw);
            m_out = o;
            m_clip = (o != raw);
            if (!(wr && sel)) begin
                m_cnt  = m_cnt + 48'd1;
                m_psum = m_psum + 48'(longint'(raw));
                m_psq  = m_psq + 48'(longint'(raw * raw));
                m_osum = m_osum + 48'(longint'(o));
                m_osq  = m_osq + 48'(longint'(o * o));
            end
        end
        if (wr && sel) begin
            m_cnt = '0; m_psum = '0; m_psq = '0; m_osum = '0; m_osq = '0;
        end
        if (wr && !sel) m_inj = wd;
        @(negedge clk);
        check_outputs();
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1 reset state
        check_outputs();
        chk(noise_req == 1'b0, "R1 noise_req at reset", noise_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 mapping, injection off; R5 noise ignored
        step(1, 1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(1, 1, 255, 0, 0, 0);
        step(1, 0, -256, 0, 0, 0);
        // R12 idle cycles
        step(0, 1, 100, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        // R11 enable, applies next cycle: sample in the write cycle is clean
        step(1, 1, 50, 1, 0, 1);
        // R3 in-range sums; R4 limits
        step(1, 1, 63, 0, 0, 0);
        step(1, 1, 64, 0, 0, 0);
        step(1, 0, -64, 0, 0, 0);
        step(1, 0, -65, 0, 0, 0);
        step(1, 1, 255, 0, 0, 0);
        step(1, 0, -256, 0, 0, 0);
        step(1, 1, -256, 0, 0, 0);
        step(1, 0, 255, 0, 0, 0);
        // R10 clear with simultaneous sample
        step(1, 1, 10, 1, 1, 0);
        step(0, 0, 0, 0, 0, 0);
        // R11 disable; the write-cycle sample still carries noise
        step(1, 0, 30, 1, 0, 0);
        step(1, 0, 30, 0, 0, 0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            bit w;
            r = int'($urandom_range(0, 99));
            w = (r < 6);
            step(r >= 15, 1'($urandom), int'($signed(9'($urandom))),
                 w, (r < 2), 1'($urandom));
        end
        // R10 final clear
        step(0, 0, 0, 1, 1, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule